// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block generates the external bus cycles of an 8-bit controller whose program and data memory sit outside the chip. One 8-bit port carries the low address byte and then the data, and a second port carries the high address byte. The address-latch strobe `ale` tells an external latch when to capture the low byte. The program-store strobe `psen_n` reads code, and `rd_n` or `wr_n` moves a data byte. The clock is the oscillator clock. A machine cycle lasts 12 clock periods, numbered 0 to 11 below.

The CPU side sees `take` high in the last period of every machine cycle. On the clock edge that ends that period, the block latches the request for the next machine cycle. A request is a kind code, a write flag, a 16-bit address, write data, and the second port's own output register value `p2_reg`. An opcode-fetch cycle does two code reads, at the address and at the address plus one, so it gives two ALE pulses and two program-store pulses. A data cycle gives one ALE pulse, no program-store pulse and one read or write strobe. So each data access drops one address-latch pulse and two program-store pulses from the steady fetch cadence. Read bytes come back on `rdata`, marked by a one-period `rdata_valid`.

The FSM states are `ST_BOOT`, `ST_FADDR`, `ST_FHOLD`, `ST_FCODE`, `ST_DADDR`, `ST_DHOLD`, `ST_DSETUP`, `ST_DSTRB` and `ST_DRECOV`. Each state stays for a fixed number of periods:

| State | Periods |
|---|---|
| ST_FADDR, ST_DADDR | 2 |
| ST_FHOLD, ST_DHOLD | 1 |
| ST_FCODE | 3 |
| ST_DSETUP | 2 |
| ST_DSTRB | 6 |
| ST_DRECOV | 1 |

The transitions are:

- Reset goes to ST_BOOT.
- ST_BOOT, the second ST_FCODE of a fetch cycle, and ST_DRECOV each go to ST_DADDR if the incoming request is a data access, and to ST_FADDR otherwise.
- The first ST_FCODE of a fetch cycle goes to ST_FADDR.
- The fixed chains are ST_FADDR, ST_FHOLD, ST_FCODE and ST_DADDR, ST_DHOLD, ST_DSETUP, ST_DSTRB, ST_DRECOV.

Top module: `xmem_bus_seq`

## Requirements
- R1: While `rst_n` is low: `ale` is 0; `psen_n`, `rd_n` and `wr_n` are 1; `p0_oe` and `rdata_valid` are 0; `take` is 1.
- R2: `take` is high for exactly one period in every 12. The request inputs are latched on the edge that ends that period.
- R3: A fetch cycle pulses `ale` high in periods 0-1 and 6-7. It drives `psen_n` low in periods 3-5 and 9-11. `rd_n` and `wr_n` stay high.
- R4: In a fetch cycle, `p0_oe` is 1 and `p0_out` holds the low byte of the fetch address in periods 0-2 and 6-8. Periods 0-5 use the request address A, and periods 6-11 use A+1 (16-bit wrap). `p2_out` holds the high byte of the same address.
- R5: Whenever `psen_n` or `rd_n` is low, `p0_oe` is 0. The `p0_in` byte from the last low period of that strobe appears on `rdata`, with `rdata_valid` high for the one following period.
- R6: A data cycle pulses `ale` only in periods 0-1 and keeps `psen_n` high. Its strobe (`rd_n` for a read, `wr_n` for a write) is low in periods 5-10 and high in period 11. In periods 0-2, `p0_out` drives the low address byte.
- R7: In a data write, `p0_oe` is 1 in all 12 periods and `p0_out` carries the write data from period 3 through period 11. In a data read, `p0_oe` is 0 from period 3 through period 11.
- R8: In a 16-bit data cycle, `p2_out` carries the address high byte. In an 8-bit data cycle, `p2_out` carries `p2_reg` in all 12 periods.
- R9: Kind encoding: 0 is fetch, 1 is 16-bit data, 2 is 8-bit data, and 3 behaves exactly as fetch. `cyc_wr` has no effect on a fetch cycle.
- R10: At most one of `psen_n`, `rd_n`, `wr_n` is low at any time, and none is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_kind | input | 2 | Request kind: 0 fetch, 1 data 16-bit, 2 data 8-bit, 3 fetch |
| cyc_wr | input | 1 | Data access is a write |
| cyc_addr | input | 16 | Request address |
| cyc_wdata | input | 8 | Write data |
| p2_reg | input | 8 | Second port's own output register value |
| p0_in | input | 8 | Byte read from the multiplexed port |
| take | output | 1 | Last period of a machine cycle; request is latched at its end |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Multiplexed port output value |
| p0_oe | output | 1 | Multiplexed port output enable |
| p2_out | output | 8 | Second port output value |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | `rdata` is new in this period |

## Verification
A wrong state or dwell count moves a strobe edge. That shows up within the same machine cycle as an ALE or strobe pulse of the wrong width, a strobe in the wrong period, or `take` arriving off its 12-period grid. A wrong half flag or a stale latched request shows up as a wrong address byte on either port at the next ALE, and so as a wrong byte returned by the modelled memory one period after the strobe rises. The bench keeps a period-by-period expected pin image and a queue of expected read bytes, so any such slip is caught in the period where it happens.

// File: rtl/xmem_bus_pkg.sv
package xmem_bus_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int CNT_W  = 3;

    localparam int T_ALE   = 2;
    localparam int T_HOLD  = 1;
    localparam int T_CODE  = 3;
    localparam int T_SETUP = 2;
    localparam int T_STRB  = 6;
    localparam int T_RECOV = 1;

    typedef enum logic [3:0] {
        ST_BOOT, ST_FADDR, ST_FHOLD, ST_FCODE,
        ST_DADDR, ST_DHOLD, ST_DSETUP, ST_DSTRB, ST_DRECOV
    } st_e;

    typedef struct packed {
        logic              is_data;
        logic              is_wr;
        logic              wide;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic logic kind_is_data(logic [1:0] k);
        return (k == 2'd1) || (k == 2'd2);
    endfunction
endpackage

// File: rtl/xmem_req_latch.sv
module xmem_req_latch
    import xmem_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [1:0]        cyc_kind,
    input  logic              cyc_wr,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_wdata,
    output logic              start_data,
    output req_t              req
);
    assign start_data = kind_is_data(cyc_kind);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else if (take) begin
            req.is_data <= start_data;
            req.is_wr   <= start_data & cyc_wr;
            req.wide    <= (cyc_kind != 2'd2);
            req.addr    <= cyc_addr;
            req.wdata   <= cyc_wdata;
        end
    end
endmodule

// File: rtl/xmem_seq_fsm.sv
module xmem_seq_fsm
    import xmem_bus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_data,
    output st_e  state,
    output logic half,
    output logic last,
    output logic take
);
    logic [CNT_W-1:0] cnt;
    st_e              nxt;

    function automatic logic [CNT_W-1:0] dwell(st_e s);
        case (s)
            ST_FADDR, ST_DADDR: return CNT_W'(T_ALE - 1);
            ST_FHOLD, ST_DHOLD: return CNT_W'(T_HOLD - 1);
            ST_FCODE:           return CNT_W'(T_CODE - 1);
            ST_DSETUP:          return CNT_W'(T_SETUP - 1);
            ST_DSTRB:           return CNT_W'(T_STRB - 1);
            ST_DRECOV:          return CNT_W'(T_RECOV - 1);
            default:            return '0;
        endcase
    endfunction

    assign last = (cnt == '0);
    assign take = last && ((state == ST_BOOT) || (state == ST_DRECOV) ||
                           ((state == ST_FCODE) && half));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:   nxt = start_data ? ST_DADDR : ST_FADDR;
            ST_FADDR:  nxt = ST_FHOLD;
            ST_FHOLD:  nxt = ST_FCODE;
            ST_FCODE:  nxt = (half && start_data) ? ST_DADDR : ST_FADDR;
            ST_DADDR:  nxt = ST_DHOLD;
            ST_DHOLD:  nxt = ST_DSETUP;
            ST_DSETUP: nxt = ST_DSTRB;
            ST_DSTRB:  nxt = ST_DRECOV;
            ST_DRECOV: nxt = start_data ? ST_DADDR : ST_FADDR;
            default:   nxt = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BOOT;
            cnt   <= '0;
            half  <= 1'b0;
        end else if (last) begin
            state <= nxt;
            cnt   <= dwell(nxt);
            if (state == ST_FCODE) half <= ~half;
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/xmem_pin_drive.sv
module xmem_pin_drive
    import xmem_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  st_e               state,
    input  logic              half,
    input  logic              last,
    input  req_t              req,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic [DATA_W-1:0] p0_in,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    logic [ADDR_W-1:0] cur_addr;
    logic              capture;

    assign cur_addr = req.addr + ADDR_W'(half);

    always_comb begin
        ale    = 1'b0;
        psen_n = 1'b1;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        p0_oe  = 1'b0;
        p0_out = '0;
        p2_out = cur_addr[ADDR_W-1 -: HI_W];
        unique case (state)
            ST_BOOT: p2_out = p2_reg;
            ST_FADDR: begin
                ale    = 1'b1;
                p0_oe  = 1'b1;
                p0_out = cur_addr[DATA_W-1:0];
            end
            ST_FHOLD: begin
                p0_oe  = 1'b1;
                p0_out = cur_addr[DATA_W-1:0];
            end
            ST_FCODE: psen_n = 1'b0;
            ST_DADDR: begin
                ale    = 1'b1;
                p0_oe  = 1'b1;
                p0_out = req.addr[DATA_W-1:0];
            end
            ST_DHOLD: begin
                p0_oe  = 1'b1;
                p0_out = req.addr[DATA_W-1:0];
            end
            ST_DSETUP, ST_DRECOV: begin
                p0_oe  = req.is_wr;
                p0_out = req.is_wr ? req.wdata : '0;
            end
            ST_DSTRB: begin
                rd_n   = req.is_wr;
                wr_n   = ~req.is_wr;
                p0_oe  = req.is_wr;
                p0_out = req.is_wr ? req.wdata : '0;
            end
            default: ;
        endcase
        if (req.is_data && !req.wide && state != ST_FADDR &&
            state != ST_FHOLD && state != ST_FCODE)
            p2_out = p2_reg;
    end

    assign capture = last && ((state == ST_FCODE) ||
                              ((state == ST_DSTRB) && !req.is_wr));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= capture;
            if (capture) rdata <= p0_in;
        end
    end
endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
    import xmem_bus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cyc_kind,
    input  logic              cyc_wr,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic [DATA_W-1:0] cyc_wdata,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic [DATA_W-1:0] p0_in,
    output logic              take,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] p0_out,
    output logic              p0_oe,
    output logic [DATA_W-1:0] p2_out,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid
);
    req_t req;
    st_e  state;
    logic start_data;
    logic half;
    logic last;

    xmem_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .take(take), .cyc_kind(cyc_kind),
        .cyc_wr(cyc_wr), .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata),
        .start_data(start_data), .req(req)
    );

    xmem_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_data(start_data),
        .state(state), .half(half), .last(last), .take(take)
    );

    xmem_pin_drive u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .half(half), .last(last),
        .req(req), .p2_reg(p2_reg), .p0_in(p0_in),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );
endmodule

// File: rtl/xmem_bus_seq_chk.sv
module xmem_bus_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic       p0_oe,
    input logic [7:0] p0_out
);
    logic [3:0] low_rd, low_wr, low_ps;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_rd <= '0;
            low_wr <= '0;
            low_ps <= '0;
        end else begin
            low_rd <= rd_n   ? 4'd0 : low_rd + 4'd1;
            low_wr <= wr_n   ? 4'd0 : low_wr + 4'd1;
            low_ps <= psen_n ? 4'd0 : low_ps + 4'd1;
        end
    end

    p_ale_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |=> ale ##1 !ale);
    p_psen_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(psen_n) |-> low_ps == 4'd3);
    p_rd_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> low_rd == 4'd6);
    p_wr_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> low_wr == 4'd6);
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> p0_oe && $stable(p0_out));
    p_read_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !p0_oe);
    p_wdata_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> p0_oe && $stable(p0_out));
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n, ale}) <= 1);
endmodule

bind xmem_bus_seq xmem_bus_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .p0_oe(p0_oe), .p0_out(p0_out)
);

// File: tb/xmem_bus_seq_bench.sv
module xmem_bus_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cyc_kind = 2'd0;
    logic       cyc_wr = 1'b0;
    logic [15:0] cyc_addr = '0;
    logic [7:0] cyc_wdata = '0;
    logic [7:0] p2_reg = '0;
    logic [7:0] p0_in;
    logic       take, ale, psen_n, rd_n, wr_n, p0_oe, rdata_valid;
    logic [7:0] p0_out, p2_out, rdata;
    logic [7:0] lat_lo = '0;

    int checks = 0;
    int errors = 0;
    int cyc_cnt = 0;
    int last_take = -1;

    typedef struct {
        bit ale, psn, rdn, wrn, oe;
        logic [7:0] p0, p2;
        bit dat, wr, alt;
        int ph;
    } snap_t;
    snap_t exp_q[$];
    logic [7:0] rd_q[$];

    always #2.5 clk = ~clk;

    xmem_bus_seq u_xmem_bus_seq (
        .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .cyc_wr(cyc_wr),
        .cyc_addr(cyc_addr), .cyc_wdata(cyc_wdata), .p2_reg(p2_reg),
        .p0_in(p0_in), .take(take), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
        .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
        .rdata(rdata), .rdata_valid(rdata_valid)
    );

    function automatic logic [7:0] mem(logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    // external address latch and memory model
    always @(negedge ale) lat_lo = p0_out;
    assign p0_in = (!psen_n || !rd_n) ? mem({p2_out, lat_lo}) : 8'h00;

    always @(posedge clk) cyc_cnt++;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string tg(snap_t s, string fetch_t, string data_t);
        if (s.alt) return "R9";
        return s.dat ? data_t : fetch_t;
    endfunction

    // driver: waits for take, applies request, pushes the expected pin image
    task automatic issue(logic [1:0] k, bit w, logic [15:0] a, logic [7:0] wd,
                         logic [7:0] p2r);
        bit dat;
        while (!take) @(negedge clk);
        if (last_take >= 0)
            chk(cyc_cnt - last_take == 12, "R2", "take spacing", cyc_cnt - last_take, 12);
        last_take = cyc_cnt;
        cyc_kind = k; cyc_wr = w; cyc_addr = a; cyc_wdata = wd; p2_reg = p2r;
        dat = (k == 2'd1) || (k == 2'd2);
        for (int p = 0; p < 12; p++) begin
            snap_t s;
            logic [15:0] fa;
            s.dat = dat; s.wr = w && dat; s.alt = (k == 2'd3); s.ph = p;
            if (!dat) begin
                fa = a + 16'(p / 6);
                s.ale = (p % 6) < 2;
                s.psn = !((p % 6) >= 3);
                s.rdn = 1'b1; s.wrn = 1'b1;
                s.oe  = (p % 6) < 3;
                s.p0  = fa[7:0];
                s.p2  = fa[15:8];
            end else begin
                s.ale = p < 2;
                s.psn = 1'b1;
                s.rdn = !(!w && p >= 5 && p <= 10);
                s.wrn = !( w && p >= 5 && p <= 10);
                s.oe  = (p < 3) || w;
                s.p0  = (p < 3) ? a[7:0] : wd;
                s.p2  = (k == 2'd1) ? a[15:8] : p2r;
            end
            exp_q.push_back(s);
        end
        if (!dat) begin
            rd_q.push_back(mem(a));
            rd_q.push_back(mem(a + 16'd1));
        end else if (!w) begin
            rd_q.push_back(mem((k == 2'd1) ? a : {p2r, a[7:0]}));
        end
        @(negedge clk);
    endtask

    // monitor: compares pins against the expected image, and read bytes
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            snap_t s;
            s = exp_q.pop_front();
            chk(ale == s.ale, tg(s, "R3", "R6"), $sformatf("ale ph%0d", s.ph), ale, s.ale);
            chk(psen_n == s.psn, tg(s, "R3", "R6"), $sformatf("psen_n ph%0d", s.ph), psen_n, s.psn);
            chk(rd_n == s.rdn, tg(s, "R3", "R6"), $sformatf("rd_n ph%0d", s.ph), rd_n, s.rdn);
            chk(wr_n == s.wrn, tg(s, "R3", "R6"), $sformatf("wr_n ph%0d", s.ph), wr_n, s.wrn);
            chk(p0_oe == s.oe, tg(s, "R5", s.wr ? "R7" : "R5"), $sformatf("p0_oe ph%0d", s.ph), p0_oe, s.oe);
            if (s.oe)
                chk(p0_out == s.p0, tg(s, "R4", (s.ph < 3) ? "R6" : "R7"),
                    $sformatf("p0_out ph%0d", s.ph), p0_out, s.p0);
            chk(p2_out == s.p2, tg(s, "R4", "R8"), $sformatf("p2_out ph%0d", s.ph), p2_out, s.p2);
        end
        if (rst_n)
            chk($countones({!psen_n, !rd_n, !wr_n, ale}) <= 1, "R10", "strobe overlap",
                {!psen_n, !rd_n, !wr_n, ale}, 0);
        if (rdata_valid) begin
            if (rd_q.size() == 0) chk(1'b0, "R5", "unexpected rdata_valid", rdata, 0);
            else begin
                logic [7:0] e;
                e = rd_q.pop_front();
                chk(rdata == e, "R5", "rdata", rdata, e);
            end
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ale == 1'b0, "R1", "ale in reset", ale, 0);
        chk({psen_n, rd_n, wr_n} == 3'b111, "R1", "strobes in reset", {psen_n, rd_n, wr_n}, 7);
        chk(p0_oe == 1'b0, "R1", "p0_oe in reset", p0_oe, 0);
        chk(rdata_valid == 1'b0, "R1", "rdata_valid in reset", rdata_valid, 0);
        chk(take == 1'b1, "R1", "take in reset", take, 1);
        rst_n = 1'b1;
        issue(2'd0, 1'b0, 16'h1234, 8'h00, 8'hEE);  // fetch
        issue(2'd0, 1'b0, 16'h12FF, 8'h00, 8'h11);  // fetch, +1 carries into high byte
        issue(2'd1, 1'b0, 16'hBEEF, 8'h00, 8'h22);  // 16-bit read
        issue(2'd1, 1'b1, 16'h4000, 8'hA5, 8'h33);  // 16-bit write
        issue(2'd2, 1'b0, 16'h5537, 8'h00, 8'hC3);  // 8-bit read
        issue(2'd2, 1'b1, 16'h9981, 8'h3C, 8'h7E);  // 8-bit write
        issue(2'd1, 1'b0, 16'h0102, 8'h00, 8'h44);  // read right after write
        issue(2'd3, 1'b1, 16'h0F0F, 8'hFF, 8'h55);  // R9: code 3 with wr set acts as fetch
        issue(2'd0, 1'b1, 16'hFFFF, 8'hFF, 8'h66);  // R9 wr ignored, R4 wrap
        issue(2'd2, 1'b0, 16'h00F0, 8'h00, 8'h0A);
        while (exp_q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rd_q.size() == 0, "R5", "read bytes outstanding", rd_q.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule